// File: doc/BRIEF.md
# Streaming Byte Checksum Generator and Checker

This block computes an 8-bit integrity byte over a stream of data bytes. It adds the bytes of a block modulo 256 and drops every carry. In generate mode it returns the two's complement of that sum. Stored next to the data, this byte brings the whole block to a total of zero. In check mode the stored checksum arrives as the last byte of the block. The block then reports one flag that tells whether the complete block adds up to zero.

Bytes enter through a valid/ready handshake. Each beat carries a first-of-block marker, a last-of-block marker and a keep bit that says whether the byte counts. The first accepted beat of a block restarts the sum and fixes the mode for that block. One cycle after the last beat is accepted, a single-cycle result strobe presents the result. A new block may start in the cycle right after the previous block's last beat.

Top module: `cksum_unit`

## Requirements
- R1: While rstN is low, inReady, resValid and resPass are 0 and resSum is 0x00.
- R2: In generate mode, the cycle after the last beat is accepted, resSum equals (256 - S) mod 256 and resPass is 0. S is the modulo-256 sum of the counted bytes of the block.
- R3: In check mode, the cycle after the last beat is accepted, resPass is 1 exactly when S is 0, and resSum is 0x00.
- R4: An accepted beat with inFirst=1 discards any earlier sum. Blocks may follow one another with no idle cycle between them.
- R5: A beat with inKeep=0 adds nothing to S. A block made only of such beats yields resSum 0x00 in generate mode and resPass 1 in check mode.
- R6: A beat is accepted only when inValid and inReady are both 1. A beat that is not accepted changes neither the sum nor the outputs. inReady rises in the first cycle after reset is released.
- R7: modeCheck is sampled on the accepted first beat of a block (1 = check, 0 = generate). Its value on later beats of the block is ignored.
- R8: The generate-mode result for the bytes 0x38, 0x23, 0x33, 0x07 is 0x6B.
- R9: resValid is high for exactly one cycle after each accepted beat with inLast=1, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Beat offered |
| inReady | output | 1 | Block can accept a beat |
| inData | input | DATA_W | Data or stored checksum byte |
| inFirst | input | 1 | Beat opens a block |
| inLast | input | 1 | Beat closes a block |
| inKeep | input | 1 | Byte counts toward the sum |
| modeCheck | input | 1 | 1 = check, 0 = generate; sampled on first beat |
| resValid | output | 1 | Result strobe |
| resSum | output | DATA_W | Generated checksum (0 in check mode) |
| resPass | output | 1 | Check result (0 in generate mode) |

## Verification
The hardest case to reach is a beat that combines several markers at once. Examples are a block that is one beat long, a first beat arriving straight after a last beat, a non-counted byte on a block edge, and idle cycles that carry stray marker and mode values. The bench sends every single-byte block in both modes back to back. It sends every two-byte check block with the right checksum and with a wrong one. It then runs a long pseudo-random series of blocks with gaps, dropped bytes and a mode input that changes after the first beat, and computes each expected byte arithmetically.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  // Per-beat strobes from control to datapath
  typedef struct packed {
    logic clear;      // accepted first beat: restart the sum
    logic accum;      // accepted counted byte
    logic finish;     // accepted last beat: capture result
    logic checkMode;  // mode in force for this beat's block
  } cksumStrobe_t;
endpackage

// File: rtl/cksum_ctrl.sv
module cksum_ctrl
  import cksum_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inFirst,
  input  logic         inLast,
  input  logic         inKeep,
  input  logic         modeCheck,
  output logic         inReady,
  output logic         resValid,
  output cksumStrobe_t strb
);
  logic readyQ;
  logic modeQ;
  logic validQ;
  logic accept;

  assign accept = inValid & readyQ;

  always_comb begin
    strb.clear     = accept & inFirst;
    strb.accum     = accept & inKeep;
    strb.finish    = accept & inLast;
    // first beat uses the live mode, later beats the one held for the block
    strb.checkMode = inFirst ? modeCheck : modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      modeQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      validQ <= strb.finish;
      if (accept && inFirst) modeQ <= modeCheck;
    end
  end

  assign inReady  = readyQ;
  assign resValid = validQ;
endmodule

// File: rtl/cksum_dp.sv
module cksum_dp
  import cksum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cksumStrobe_t      strb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] resSum,
  output logic              resPass
);
  localparam logic [DATA_W-1:0] ZERO = {DATA_W{1'b0}};

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sumNext;
  logic [DATA_W-1:0] sumQ;
  logic              passQ;

  always_comb begin
    base    = strb.clear ? ZERO : accQ;
    addend  = strb.accum ? inData : ZERO;
    sumNext = base + addend;  // carries drop off the top
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= ZERO;
      sumQ  <= ZERO;
      passQ <= 1'b0;
    end else begin
      if (strb.clear || strb.accum) accQ <= sumNext;
      if (strb.finish) begin
        sumQ  <= strb.checkMode ? ZERO : (ZERO - sumNext);
        passQ <= strb.checkMode && (sumNext == ZERO);
      end
    end
  end

  assign resSum  = sumQ;
  assign resPass = passQ;
endmodule

// File: rtl/cksum_unit.sv
module cksum_unit
  import cksum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic              inKeep,
  input  logic              modeCheck,
  output logic              resValid,
  output logic [DATA_W-1:0] resSum,
  output logic              resPass
);
  cksumStrobe_t strb;

  cksum_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .inLast   (inLast),
    .inKeep   (inKeep),
    .modeCheck(modeCheck),
    .inReady  (inReady),
    .resValid (resValid),
    .strb     (strb)
  );

  cksum_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inData (inData),
    .resSum (resSum),
    .resPass(resPass)
  );
endmodule

// File: rtl/cksum_unit_chk.sv
module cksum_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              inLast,
  input logic              resValid,
  input logic [DATA_W-1:0] resSum,
  input logic              resPass
);
  logic endBeat;
  assign endBeat = inValid && inReady && inLast;

  // R1: outputs quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!resValid && !inReady && !resPass && resSum == '0));

  // R9: an accepted last beat is followed by the strobe
  p_result_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    endBeat |=> resValid);

  // R9: no strobe without an accepted last beat
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    !endBeat |=> !resValid);

  // R6: results move only on an accepted last beat
  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    !endBeat |=> ($stable(resSum) && $stable(resPass)));

  // R3: a pass report carries a zero sum field
  p_pass_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resPass) |-> (resSum == '0));
endmodule

bind cksum_unit cksum_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .inLast  (inLast),
  .resValid(resValid),
  .resSum  (resSum),
  .resPass (resPass)
);

// File: tb/cksum_unit_bench.sv
`timescale 1ns/1ps
module cksum_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = 8'h00;
  logic       inFirst = 1'b0;
  logic       inLast = 1'b0;
  logic       inKeep = 1'b0;
  logic       modeCheck = 1'b0;
  logic       resValid;
  logic [7:0] resSum;
  logic       resPass;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic [7:0] mSum = 8'h00;
  logic       mMode = 1'b0;
  bit         pend = 0;
  logic [7:0] expSum;
  logic       expPass;
  string      tag = "R2";
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  cksum_unit #(.DATA_W(8)) u_cksum_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inFirst(inFirst), .inLast(inLast), .inKeep(inKeep),
    .modeCheck(modeCheck), .resValid(resValid), .resSum(resSum),
    .resPass(resPass)
  );

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare at the current (falling-edge) time against the pending result
  task automatic observe();
    if (pend) begin
      chk({tag, "/R9 strobe"}, 32'(resValid), 1);
      chk({tag, " sum"}, 32'(resSum), 32'(expSum));
      chk({tag, " pass"}, 32'(resPass), 32'(expPass));
      pend = 0;
    end else begin
      chk("R9 idle strobe", 32'(resValid), 0);
    end
  endtask

  task automatic beat(input logic v, input logic [7:0] d, input logic f,
                      input logic l, input logic k, input logic m);
    @(negedge clk);
    observe();
    if (v) begin
      if (f) begin mSum = 8'h00; mMode = m; end
      if (k) mSum = mSum + d;
      if (l) begin
        pend    = 1;
        expSum  = mMode ? 8'h00 : 8'(8'h00 - mSum);
        expPass = mMode && (mSum == 8'h00);
      end
    end
    inValid = v; inData = d; inFirst = f; inLast = l; inKeep = k; modeCheck = m;
  endtask

  task automatic idleJunk();
    seed = rnd(seed);
    beat(1'b0, seed[7:0], seed[8], seed[9], seed[10], seed[11]);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(inReady), 0);
    chk("R1 strobe", 32'(resValid), 0);
    chk("R1 sum", 32'(resSum), 0);
    chk("R1 pass", 32'(resPass), 0);

    // R6: a beat offered as reset releases is not taken (ready still low)
    rstN = 1'b1;
    inValid = 1'b1; inData = 8'h55; inFirst = 1'b1; inLast = 1'b1; inKeep = 1'b1;
    @(negedge clk);
    chk("R6 ready after reset", 32'(inReady), 1);
    chk("R6 not accepted", 32'(resValid), 0);
    inValid = 1'b0;
    @(negedge clk);
    chk("R6 no result", 32'(resValid), 0);
    chk("R6 sum held", 32'(resSum), 0);

    // R8: worked example
    tag = "R8";
    beat(1, 8'h38, 1, 0, 1, 0);
    beat(1, 8'h23, 0, 0, 1, 0);
    beat(1, 8'h33, 0, 0, 1, 0);
    beat(1, 8'h07, 0, 1, 1, 0);
    beat(0, 8'h00, 0, 0, 0, 0);
    chk("R8 literal", 32'(expSum), 32'h6B);

    // R2/R4: every single-byte generate block, back to back
    tag = "R2/R4";
    for (int b = 0; b < 256; b++) beat(1, 8'(b), 1, 1, 1, 0);
    // R3/R4: every single-byte check block
    tag = "R3/R4";
    for (int b = 0; b < 256; b++) beat(1, 8'(b), 1, 1, 1, 1);
    // R3: two-byte check blocks, correct and wrong checksum
    tag = "R3";
    for (int b = 0; b < 256; b++) begin
      beat(1, 8'(b), 1, 0, 1, 1);
      beat(1, 8'(8'h00 - 8'(b)), 0, 1, 1, 1);
      beat(1, 8'(b), 1, 0, 1, 1);
      beat(1, 8'(8'h01 - 8'(b)), 0, 1, 1, 1);
    end

    // R5: empty blocks
    tag = "R5 empty gen";
    beat(1, 8'hA7, 1, 1, 0, 0);
    tag = "R5 empty chk";
    beat(1, 8'h3C, 1, 1, 0, 1);
    tag = "R5 dropped bytes";
    beat(1, 8'h10, 1, 0, 1, 0);
    beat(1, 8'hFF, 0, 0, 0, 0);
    beat(1, 8'h20, 0, 1, 1, 0);
    beat(0, 8'h00, 0, 0, 0, 0);

    // R7: mode toggled after the first beat
    tag = "R7";
    beat(1, 8'h11, 1, 0, 1, 0);
    beat(1, 8'h22, 0, 0, 1, 1);
    beat(1, 8'h33, 0, 1, 1, 1);
    beat(1, 8'h44, 1, 0, 1, 1);
    beat(1, 8'hBC, 0, 1, 1, 0);
    beat(0, 8'h00, 0, 0, 0, 0);

    // R4/R5/R6/R7: pseudo-random blocks with gaps, drops, mode noise
    tag = "R4/R6 mix";
    for (int blk = 0; blk < 400; blk++) begin
      int len;
      logic bm, fix;
      seed = rnd(seed);
      len = 1 + int'(seed[3:0] % 12);
      bm  = seed[4];
      fix = seed[5];
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        logic k;
        seed = rnd(seed);
        if (seed[1:0] == 2'b00) idleJunk();
        seed = rnd(seed);
        d = seed[7:0];
        k = (seed[10:8] != 3'b000);
        if (i == len - 1 && bm && fix) begin
          d = 8'h00 - ((i == 0) ? 8'h00 : mSum);
          k = 1'b1;
        end
        beat(1, d, i == 0, i == len - 1, k, (i == 0) ? bm : seed[12]);
      end
    end
    beat(0, 8'h00, 0, 0, 0, 0);
    beat(0, 8'h00, 0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule